// File: doc/BRIEF.md
# SPI Status Poll Engine

This block is an SPI master (mode 0) that keeps reading a one-byte hardware status register from a slave until a condition holds. A single-cycle `start_i` accepts an 8-bit condition mask. From then on the engine repeats status samples with no enforced pause between them. It stops when one of three things happens:

- the sampled status reports a fault;
- the busy bit is clear and every requested mask bit is set;
- a clock-cycle budget runs out.

Each status sample is two identical one-byte chip-select frames that send the status opcode `0x00`. The slave's answer comes back on MISO in that same byte. The byte from the first frame is thrown away, because it can be stale, and only the byte from the second frame is judged. A single-cycle `done_o` ends every poll. When it fires, `status_o` holds the last judged byte, and `err_o` or `tmo_o` gives the reason if the poll did not succeed.

The controller uses five states:

- **S_IDLE** waits for a start.
- **S_GAP** holds chip select high for one SCLK period.
- **S_LAUNCH** drops chip select and fires the byte shifter.
- **S_SHIFT** waits for the byte to complete.
- **S_JUDGE** evaluates the second byte of a sample.

The transitions are:

- S_IDLE→S_GAP on an accepted start.
- S_GAP→S_LAUNCH when the gap count expires.
- S_LAUNCH→S_SHIFT unconditionally.
- S_SHIFT→S_GAP after the first frame of a sample.
- S_SHIFT→S_JUDGE after the second frame.
- S_JUDGE→S_IDLE on fault, on success or on an exhausted budget.
- S_JUDGE→S_GAP otherwise, to take another sample.

Top module: `spi_stat_poll`

## Requirements
- R1: Each frame holds `cs_n_o` low for exactly 8 SCLK pulses, with `sclk_o` low whenever `cs_n_o` is high. The opcode byte 0x00 goes out on `mosi_o` MSB first. MISO is sampled MSB first on each rising SCLK edge.
- R2: Every status sample is two frames. Only the byte received in the second frame is judged and reported on `status_o`.
- R3: Before every frame, `cs_n_o` stays high for at least one SCLK period, which is 2*CLK_HALF clocks.
- R4: If a judged status byte has bit 2 (violation) or bit 3 (fault) set, the poll ends with `done_o` and `err_o`=1. This outcome has priority over success and timeout.
- R5: With no fault bit set, the poll succeeds (`done_o` with `err_o`=`tmo_o`=0) when (status & (0x01 | mask)) == mask, where bit 0 is busy and bit 1 is ready. Bits outside the mask, such as 4 to 7, are ignored.
- R6: The budget restarts on each accepted start. A sample judged at least TIMEOUT_CYCLES clocks after the start that neither faults nor succeeds ends the poll with `tmo_o`=1.
- R7: `done_o` is a one-cycle pulse. `err_o`, `tmo_o` and `status_o` hold their values until the next accepted start, and `err_o` and `tmo_o` are never both high.
- R8: `start_i` and `mask_i` are ignored while a poll is in progress.
- R9: After reset, `cs_n_o`=1, `sclk_o`=0, and `done_o`, `err_o`, `tmo_o` and `status_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only in S_IDLE |
| mask_i | input | 8 | Status bits that must be set for success |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the slave |
| cs_n_o | output | 1 | Active-low chip select |
| done_o | output | 1 | One-cycle end-of-poll pulse |
| status_o | output | 8 | Last judged status byte |
| err_o | output | 1 | Poll ended on a fault bit |
| tmo_o | output | 1 | Poll ended on budget exhaustion |

## Verification
The wrong internal states show up at the ports in different ways:

- A stuck or misordered frame counter shows within one frame as a wrong number of SCLK pulses per chip-select window or a non-zero opcode.
- Judging the first frame instead of the second shows on the first sample, because the bench's slave answers every first frame with a fault pattern.
- A bad pass/fail decision or a budget counter that does not restart shows at the next `done_o` as the wrong flag, a wrong status byte, or a timeout arriving hundreds of cycles early.

// File: rtl/spi_poll_pkg.sv
`timescale 1ns/1ps
package spi_poll_pkg;
    localparam int  ST_BUSY    = 0;
    localparam int  ST_READY   = 1;
    localparam int  ST_VIOL    = 2;
    localparam int  ST_FAULT   = 3;
    localparam logic [7:0] OPC_STATUS = 8'h00;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GAP,
        S_LAUNCH,
        S_SHIFT,
        S_JUDGE
    } poll_state_t;
endpackage

// File: rtl/spi_byte_core.sv
`timescale 1ns/1ps
module spi_byte_core #(
    parameter int CLK_HALF = 2,
    parameter int NBITS    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [NBITS-1:0] tx_i,
    input  logic             miso_i,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             done_o,
    output logic [NBITS-1:0] rx_o
);
    localparam int DW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam int EW = $clog2(2 * NBITS);
    localparam logic [DW-1:0] DIV_LAST  = DW'(CLK_HALF - 1);
    localparam logic [EW-1:0] EDGE_LAST = EW'(2 * NBITS - 1);

    logic             active;
    logic [DW-1:0]    div_q;
    logic [EW-1:0]    edge_q;
    logic [NBITS-1:0] tx_sr, rx_sr;
    logic             tick;

    assign tick   = active && (div_q == DIV_LAST);
    assign mosi_o = tx_sr[NBITS-1];
    assign rx_o   = rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            div_q  <= '0;
            edge_q <= '0;
            tx_sr  <= '0;
            rx_sr  <= '0;
            sclk_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!active) begin
                if (go_i) begin
                    active <= 1'b1;
                    tx_sr  <= tx_i;
                    div_q  <= '0;
                    edge_q <= '0;
                    sclk_o <= 1'b0;
                end
            end else if (tick) begin
                div_q  <= '0;
                edge_q <= edge_q + 1'b1;
                if (!sclk_o) begin
                    sclk_o <= 1'b1;
                    rx_sr  <= {rx_sr[NBITS-2:0], miso_i};
                end else begin
                    sclk_o <= 1'b0;
                    tx_sr  <= {tx_sr[NBITS-2:0], 1'b0};
                    if (edge_q == EDGE_LAST) begin
                        active <= 1'b0;
                        done_o <= 1'b1;
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/poll_timer.sv
`timescale 1ns/1ps
module poll_timer #(
    parameter int LIMIT = 400_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic expired_o
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIM = TW'(LIMIT);

    logic [TW-1:0] cnt_q;

    assign expired_o = (cnt_q == LIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (restart_i) cnt_q <= '0;
        else if (!expired_o) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_stat_poll.sv
`timescale 1ns/1ps
module spi_stat_poll
    import spi_poll_pkg::*;
#(
    parameter int CLK_HALF       = 2,
    parameter int TIMEOUT_CYCLES = 400_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] mask_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       cs_n_o,
    output logic       done_o,
    output logic [7:0] status_o,
    output logic       err_o,
    output logic       tmo_o
);
    localparam int GAP_CYC = 2 * CLK_HALF;
    localparam int GW      = $clog2(GAP_CYC) + 1;
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);
    localparam logic [7:0] BUSY_BIT = 8'(1) << ST_BUSY;

    poll_state_t   state, nxt;
    logic [GW-1:0] gap_cnt;
    logic          second;
    logic [7:0]    mask_q;
    logic          accept, expired;
    logic          xfer_go, xfer_done;
    logic [7:0]    xfer_rx;
    logic          is_err, is_ok;

    assign accept  = (state == S_IDLE) && start_i;
    assign xfer_go = (state == S_LAUNCH);
    assign is_err  = status_o[ST_VIOL] | status_o[ST_FAULT];
    assign is_ok   = ((status_o & (BUSY_BIT | mask_q)) == mask_q);

    spi_byte_core #(.CLK_HALF(CLK_HALF), .NBITS(8)) u_core (
        .clk(clk), .rst_n(rst_n), .go_i(xfer_go), .tx_i(OPC_STATUS),
        .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o),
        .done_o(xfer_done), .rx_o(xfer_rx)
    );

    poll_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart_i(accept), .expired_o(expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start_i) nxt = S_GAP;
            S_GAP:    if (gap_cnt == GAP_LAST) nxt = S_LAUNCH;
            S_LAUNCH: nxt = S_SHIFT;
            S_SHIFT:  if (xfer_done) nxt = second ? S_JUDGE : S_GAP;
            S_JUDGE:  nxt = (is_err || is_ok || expired) ? S_IDLE : S_GAP;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_o   <= 1'b1;
            gap_cnt  <= '0;
            second   <= 1'b0;
            mask_q   <= '0;
            status_o <= '0;
            err_o    <= 1'b0;
            tmo_o    <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                S_IDLE: if (start_i) begin
                    mask_q  <= mask_i;
                    second  <= 1'b0;
                    gap_cnt <= '0;
                    err_o   <= 1'b0;
                    tmo_o   <= 1'b0;
                end
                S_GAP:    gap_cnt <= gap_cnt + 1'b1;
                S_LAUNCH: begin
                    cs_n_o  <= 1'b0;
                    gap_cnt <= '0;
                end
                S_SHIFT: if (xfer_done) begin
                    cs_n_o <= 1'b1;
                    second <= ~second;
                    if (second) status_o <= xfer_rx;
                end
                S_JUDGE: begin
                    if (is_err) begin
                        err_o  <= 1'b1;
                        done_o <= 1'b1;
                    end else if (is_ok) begin
                        done_o <= 1'b1;
                    end else if (expired) begin
                        tmo_o  <= 1'b1;
                        done_o <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spi_stat_poll_chk.sv
`timescale 1ns/1ps
module spi_stat_poll_chk #(
    parameter int GAP_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       done,
    input logic       err,
    input logic       tmo,
    input logic [7:0] status,
    input logic [7:0] mask_q
);
    logic [7:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              hi_q <= '0;
        else if (!cs_n)          hi_q <= '0;
        else if (hi_q != 8'hFF)  hi_q <= hi_q + 1'b1;
    end

    a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    a_r1_cs_high_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    a_r3_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (int'(hi_q) >= GAP_CYC));

    a_r4_err_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (status[2] || status[3])) |-> err);

    a_r5_ok_condition: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && !tmo) |-> ((status & (8'h01 | mask_q)) == mask_q));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(err && tmo));
endmodule

bind spi_stat_poll spi_stat_poll_chk #(.GAP_CYC(GAP_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n_o), .sclk(sclk_o), .done(done_o),
    .err(err_o), .tmo(tmo_o), .status(status_o), .mask_q(mask_q)
);

// File: tb/tb_spi_stat_poll.sv
`timescale 1ns/1ps
module tb_spi_stat_poll;
    localparam int HALF = 2;
    localparam int TMO  = 1500;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso;
    logic [7:0] mask = 8'h00;
    logic sclk, mosi, cs_n, done, err, tmo;
    logic [7:0] status;

    always #2.5 clk = ~clk;

    spi_stat_poll #(.CLK_HALF(HALF), .TIMEOUT_CYCLES(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mask_i(mask),
        .miso_i(miso), .sclk_o(sclk), .mosi_o(mosi), .cs_n_o(cs_n),
        .done_o(done), .status_o(status), .err_o(err), .tmo_o(tmo)
    );

    int total = 0, bad = 0;

    // slave model: first frame of every sample answers a fault pattern
    int busy_n = 0, fcnt = 0, frame_bad = 0, mo_bits = 0;
    logic [7:0] final_st = 8'h00, sl_sr = 8'h00, mo_sr = 8'h00;
    logic in_frame = 1'b0;

    function automatic logic [7:0] frame_val(int f);
        if (f % 2 == 0) return 8'h0C;
        if (f / 2 < busy_n) return 8'h01;
        return final_st;
    endfunction

    assign miso = sl_sr[7];

    always @(negedge cs_n) begin
        sl_sr = frame_val(fcnt);
        mo_bits = 0; mo_sr = 8'h00; in_frame = 1'b1;
    end
    always @(negedge sclk) if (!cs_n) sl_sr = {sl_sr[6:0], 1'b0};
    always @(posedge sclk) if (!cs_n) begin
        mo_sr = {mo_sr[6:0], mosi}; mo_bits++;
    end
    always @(posedge cs_n) if (in_frame) begin
        if (mo_bits != 8 || mo_sr != 8'h00) frame_bad++;
        fcnt++; in_frame = 1'b0;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // {mask, busy samples, final status, result 0=ok 1=err 2=tmo, samples}
    localparam logic [39:0] VEC [9] = '{
        {8'h00, 8'd0, 8'h00, 8'd0, 8'd1},
        {8'h00, 8'd2, 8'h00, 8'd0, 8'd3},
        {8'h02, 8'd1, 8'h02, 8'd0, 8'd2},
        {8'h02, 8'd0, 8'hF2, 8'd0, 8'd1},
        {8'h00, 8'd0, 8'h04, 8'd1, 8'd1},
        {8'h02, 8'd3, 8'h09, 8'd1, 8'd4},
        {8'h02, 8'd0, 8'h00, 8'd2, 8'd0},
        {8'h00, 8'd9, 8'h00, 8'd0, 8'd10},
        {8'h30, 8'd1, 8'h30, 8'd0, 8'd2}
    };

    int cyc;

    task automatic launch(input logic [7:0] m, input int bn, input logic [7:0] fs);
        busy_n = bn; final_st = fs; fcnt = 0; frame_bad = 0;
        @(negedge clk); mask = m; start = 1'b1;
        @(negedge clk); start = 1'b0; mask = 8'h00;
        cyc = 1;
    endtask

    task automatic wait_done(input int extra_start_at);
        while (!done && cyc < 4000) begin
            @(negedge clk); cyc++;
            if (cyc == extra_start_at) begin
                mask = 8'h02; start = 1'b1;
                @(negedge clk); start = 1'b0; mask = 8'h00; cyc++;
            end
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R9 reset state
        chk(cs_n == 1'b1, "R9", "cs_n in reset", cs_n, 1);
        chk(sclk == 1'b0 && done == 1'b0, "R9", "sclk|done in reset", sclk | done, 0);
        chk(err == 1'b0 && tmo == 1'b0 && status == 8'h00, "R9", "flags/status in reset",
            int'(status) + err + tmo, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R9", "idle after reset", cs_n, 1);

        for (int i = 0; i < 9; i++) begin
            logic [7:0] m, bn, fs, code, ns;
            int got;
            {m, bn, fs, code, ns} = VEC[i];
            launch(m, int'(bn), fs);
            wait_done(-1);
            got = tmo ? 2 : (err ? 1 : 0);
            chk(done === 1'b1, "R7", $sformatf("vec%0d done seen", i), done, 1);
            if (code == 8'd1)      chk(got == 1, "R4", $sformatf("vec%0d result", i), got, 1);
            else if (code == 8'd2) chk(got == 2, "R6", $sformatf("vec%0d result", i), got, 2);
            else                   chk(got == 0, "R5", $sformatf("vec%0d result", i), got, 0);
            chk(status == fs, "R2", $sformatf("vec%0d status", i), status, fs);
            chk(frame_bad == 0, "R1", $sformatf("vec%0d frame shape", i), frame_bad, 0);
            chk(fcnt % 2 == 0, "R2", $sformatf("vec%0d frames paired", i), fcnt, fcnt + fcnt % 2);
            if (code == 8'd2)
                chk(cyc >= TMO && cyc <= TMO + 120, "R6", "timeout latency", cyc, TMO);
            else
                chk(fcnt / 2 == int'(ns), "R2", $sformatf("vec%0d samples", i), fcnt / 2, ns);
            @(negedge clk);
            chk(done == 1'b0, "R7", $sformatf("vec%0d done pulse width", i), done, 0);
            repeat (3) @(negedge clk);
            chk(status == fs && (tmo ? 2 : (err ? 1 : 0)) == got, "R7",
                $sformatf("vec%0d flags held", i), status, fs);
        end

        // R8: a start with another mask mid-poll must not restart the poll
        launch(8'h00, 3, 8'h00);
        wait_done(60);
        chk(!err && !tmo, "R8", "mid-poll start ignored (result)", err + tmo, 0);
        chk(fcnt / 2 == 4, "R8", "mid-poll start ignored (samples)", fcnt / 2, 4);
        chk(cyc < TMO, "R8", "no restart into timeout", cyc, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule